// File: doc/BRIEF.md
# Framed Serial Byte Transmitter

This block turns one byte at a time into an asynchronous serial frame on a single line. Each frame is a low start bit, then eight data bits with the least significant bit first, then a high stop bit. There is no parity bit. The bit rate comes from two parameters: the system clock frequency and the line rate. The bit period in clock cycles is derived from them once, when the design is elaborated.

A user waits for `ready`, places a byte on `data` and raises `send_req` for at least one clock. The request passes through a flip-flop. A three-state controller then loads a 10-bit framing register, which holds the byte above a start bit and an idle bit. The controller also enables a bit-rate tick generator, which runs only while a frame is in progress. The register shifts right on each tick and fills from the top with 1s. The line output is a registered copy of the register's lowest bit. A bit counter ends the frame after eleven ticks. If the request is held high, frames follow each other back to back.

Top module: `uart_tx_serial`

## Requirements
- R1: The bit period is round(CLK_HZ / BAUD) clock cycles. The start bit reaches `tx` exactly DIV+2 cycles after the clock edge that samples the request, where DIV is that period.
- R2: Each frame on `tx` is one 0 (start), then `data[0]` through `data[7]` in that order, then one 1 (stop). Each bit lasts DIV cycles.
- R3: `send_req` is registered. In the cycle after the sampling edge `ready` is still 1, and it drops one edge later.
- R4: The load state lasts exactly one clock and is always followed by the sending state.
- R5: `ready` is 1 only while the controller is idle. It stays 0 for exactly 11*DIV+1 cycles per frame.
- R6: The byte is captured when a request is seen while `ready` is 1. Changes on `data` and request pulses while `ready` is 0 change neither the frame being sent nor the idle state that follows it.
- R7: While `send_req` is held at 1, a new frame starts every 11*DIV+2 cycles. The only gap between frames is the stop level and one idle bit.
- R8: `rst_n` is active low and synchronous. At the first clock edge with `rst_n` at 0, `tx` becomes 1 and `ready` becomes 1. Nothing changes before that edge.
- R9: `tx` is 1 while idle, and for one full bit period after the load, before the start bit.
- R10: The bit-rate tick is one clock wide. The framing register changes only on a load or on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| send_req | input | 1 | Request to send the byte on `data` |
| data | input | 8 | Byte to send |
| tx | output | 1 | Serial line, high when idle |
| ready | output | 1 | 1 when a new request will be accepted |

## Verification
Two events can fall in the same cycle: the controller returning to idle after the eleventh tick, and a pending request that sends it straight into the next load. The bench provokes this by holding the request high across three frames of the same byte. It checks every bit at absolute cycle positions, spaced 11*DIV+2 cycles apart, so one extra or missing cycle at the frame seam is reported. A request pulse and a data change are also placed in the cycle of the load itself, on every second byte of a full 256-value sweep. The bench then checks that the frame carries the originally captured byte and that no extra frame follows.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;

    // Cycles per bit, rounded to nearest.
    function automatic int unsigned baud_divisor(input int unsigned clk_hz,
                                                 input int unsigned baud);
        return (clk_hz + baud / 2) / baud;
    endfunction

endpackage

// File: rtl/uart_tx_baudgen.sv
module uart_tx_baudgen #(
    parameter int unsigned DIVISOR = 104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned CW = (DIVISOR > 2) ? $clog2(DIVISOR) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIVISOR - 1);

    logic [CW-1:0] cnt_q;

    // Counter is held at zero whenever disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = en && (cnt_q == LAST);

    // R10: tick is a single-cycle pulse
    a_r10_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned FRAME_W = DATA_W + 2,
    parameter int unsigned CNT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [DATA_W-1:0] byte_in,
    output logic              line_bit,
    output logic [CNT_W-1:0]  bit_count
);
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '1;
            cnt_q   <= '0;
        end else if (load) begin
            shreg_q <= {byte_in, 2'b01};
            cnt_q   <= '0;
        end else if (tick) begin
            shreg_q <= {1'b1, shreg_q[FRAME_W-1:1]};
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign line_bit  = shreg_q[0];
    assign bit_count = cnt_q;

    // R10: register holds between ticks
    a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(shreg_q));

    // R2: a load places idle bit and start bit at the bottom, counter cleared
    a_r2_load_frame: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (shreg_q[1:0] == 2'b01) && (cnt_q == '0));

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
    import uart_tx_pkg::*;
#(
    parameter int unsigned CNT_W     = 4,
    parameter int unsigned END_COUNT = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] bit_count,
    output logic             load,
    output logic             baud_en,
    output logic             ready
);
    tx_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (go) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_SEND;
            ST_SEND: if (bit_count == CNT_W'(END_COUNT)) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign load    = (state_q == ST_LOAD);
    assign baud_en = (state_q != ST_IDLE);
    assign ready   = (state_q == ST_IDLE);

    // R4: load lasts one clock, then sending
    a_r4_load_then_send: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_SEND));

    // R5: ready drops only after a registered request
    a_r5_ready_drop_on_go: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready) |-> $past(go));

    // R5: bit counter never passes the end value
    a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        bit_count <= CNT_W'(END_COUNT));

endmodule

// File: rtl/uart_tx_serial.sv
module uart_tx_serial #(
    parameter int unsigned CLK_HZ = 12_000_000,
    parameter int unsigned BAUD   = 115_200,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_req,
    input  logic [DATA_W-1:0] data,
    output logic              tx,
    output logic              ready
);
    localparam int unsigned DIVISOR   = uart_tx_pkg::baud_divisor(CLK_HZ, BAUD);
    localparam int unsigned FRAME_W   = DATA_W + 2;
    localparam int unsigned END_COUNT = FRAME_W + 1;
    localparam int unsigned CNT_W     = $clog2(END_COUNT + 1);

    logic              req_q;
    logic [DATA_W-1:0] byte_q;
    logic              tx_q;
    logic              load, baud_en, tick, line_bit;
    logic [CNT_W-1:0]  bit_count;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            byte_q <= '0;
            tx_q   <= 1'b1;
        end else begin
            req_q <= send_req;
            if (ready && send_req) byte_q <= data;
            tx_q <= ready ? 1'b1 : line_bit;
        end
    end

    uart_tx_baudgen #(
        .DIVISOR (DIVISOR)
    ) u_baud (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (baud_en),
        .tick  (tick)
    );

    uart_tx_shifter #(
        .DATA_W  (DATA_W),
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .tick      (tick),
        .byte_in   (byte_q),
        .line_bit  (line_bit),
        .bit_count (bit_count)
    );

    uart_tx_ctrl #(
        .CNT_W     (CNT_W),
        .END_COUNT (END_COUNT)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (req_q),
        .bit_count (bit_count),
        .load      (load),
        .baud_en   (baud_en),
        .ready     (ready)
    );

    assign tx = tx_q;

    // R9: line is high after a full idle cycle
    a_r9_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(ready)) |-> tx);

    // R6: captured byte is frozen while busy
    a_r6_byte_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && $past(!ready)) |-> $stable(byte_q));

endmodule

// File: tb/uart_tx_serial_bench.sv
module uart_tx_serial_bench;
    // 1000 / 270 = 3.70 cycles per bit, rounds to 4 (truncation would give 3)
    localparam int CLK_HZ = 1000;
    localparam int BAUD   = 270;
    localparam int DIV    = 4;
    localparam int P      = 11 * DIV + 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       send_req = 1'b0;
    logic [7:0] data = 8'h00;
    logic       tx, ready;

    int checks = 0;
    int errors = 0;
    int pos = 0;

    always #5 clk = ~clk;

    uart_tx_serial #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_W(8)) u_uart_tx_serial (
        .clk(clk), .rst_n(rst_n), .send_req(send_req),
        .data(data), .tx(tx), .ready(ready)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at pos %0d: actual=%0d expected=%0d", req, pos, act, exp);
        end
    endtask

    // Advance to the negedge following edge number target (counted from E0).
    task automatic adv(input int target);
        if (target > pos) begin
            repeat (target - pos) @(posedge clk);
            pos = target;
            @(negedge clk);
        end
    endtask

    task automatic launch(input logic [7:0] b, input bit hold);
        @(negedge clk);
        data = b;
        send_req = 1'b1;
        @(posedge clk);
        pos = 0;
        @(negedge clk);
        if (!hold) send_req = 1'b0;
    endtask

    task automatic check_frame(input logic [7:0] b, input int base,
                               input bit disturb, input bit drop);
        adv(base);
        chk("R3 ready still high after sampling edge", ready, 1);
        adv(base + 1);
        chk("R5 ready low in load", ready, 0);
        if (disturb) begin
            data = ~b;
            send_req = 1'b1;
        end
        if (drop) send_req = 1'b0;
        adv(base + 2);
        if (disturb) send_req = 1'b0;
        adv(base + 1 + DIV);
        chk("R9 idle bit before start", tx, 1);
        adv(base + 2 + DIV);
        chk("R1 start bit edge", tx, 0);
        for (int n = 1; n <= 10; n++) begin
            int exp;
            if (n == 1)       exp = 0;
            else if (n == 10) exp = 1;
            else              exp = b[n-2];
            adv(base + 2 + n * DIV + DIV / 2);
            chk("R2 frame bit", tx, exp);
            if (n == 1) begin
                adv(base + 1 + 2 * DIV);
                chk("R1 start bit lasts DIV", tx, 0);
                adv(base + 2 + 2 * DIV);
                chk("R1 first data bit edge", tx, b[0]);
            end
        end
        adv(base + 1 + 11 * DIV);
        chk("R5 ready low to end", ready, 0);
        adv(base + 2 + 11 * DIV);
        chk("R5 ready back", ready, 1);
        chk("R9 line high at end", tx, 1);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R8 tx in reset", tx, 1);
        chk("R8 ready in reset", ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R9 idle line", tx, 1);

        // R2 R6: full byte sweep, disturbance on odd values
        for (int v = 0; v < 256; v++) begin
            launch(8'(v), 1'b0);
            check_frame(8'(v), 0, v[0], 1'b0);
            adv(pos + 3);
            chk("R6 no extra frame", ready, 1);
            chk("R6 line idle", tx, 1);
        end

        // R7: held request, three frames back to back
        launch(8'h41, 1'b1);
        check_frame(8'h41, 0, 1'b0, 1'b0);
        check_frame(8'h41, P, 1'b0, 1'b0);
        check_frame(8'h41, 2 * P, 1'b0, 1'b1);
        adv(pos + 4);
        chk("R7 stops after release", ready, 1);
        chk("R7 line idle after release", tx, 1);

        // R8: reset in the middle of a start bit
        launch(8'h00, 1'b0);
        adv(3 + DIV);
        chk("R8 start bit before reset", tx, 0);
        rst_n = 1'b0;
        #1;
        chk("R8 synchronous: tx unchanged", tx, 0);
        chk("R8 synchronous: ready unchanged", ready, 0);
        adv(pos + 1);
        chk("R8 tx after reset edge", tx, 1);
        chk("R8 ready after reset edge", ready, 1);
        rst_n = 1'b1;
        launch(8'hA5, 1'b0);
        check_frame(8'hA5, 0, 1'b0, 1'b0);

        report();
        $finish;
    end
endmodule